// File: doc/BRIEF.md
# Sign-Magnitude Fixed-Point Arithmetic Unit

This block computes one arithmetic result at a time on 32-bit words that hold a sign bit above a 31-bit magnitude. The magnitude is fixed point: 15 integer bits above 16 fraction bits. It supports add, subtract, multiply, divide and square root. Add and subtract, and the error cases, finish in a single step. Multiply runs as a shift-and-add loop. Divide and square root run as restoring digit-by-digit loops, one result bit per clock. Each of these three iterative operations has its own fixed latency.

A command (opcode plus two operand words) enters on a valid/ready channel. `cmd_ready` is high only while the unit is idle with no result waiting, so a producer holds `cmd_valid` and its data until it sees the transfer edge. The result leaves on a second valid/ready channel. Once `res_valid` rises, the word and the three flags stay frozen until the consumer raises `res_ready`. No new command is taken until that transfer has happened. Longer functions, such as transcendental series, are built by a controller that sends sequences of these commands.

Top module: `smfx_arith_unit`

## Requirements
- R1: Word format: bit 31 is the sign (1 = negative) and bits 30:0 are the magnitude, holding 16 fraction bits. Opcode encoding: 0 add, 1 subtract (a minus b), 2 multiply, 3 divide (a by b), 4 square root of a.
- R2: `cmd_ready` is 1 after reset and whenever the unit is idle. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `res_valid` and `cmd_ready` are never 1 together. While `res_valid` is 1 and `res_ready` is 0, the result word and the flags hold their values.
- R3: Add and subtract use the effective sign of b, which is inverted for subtract. With equal effective signs, the magnitudes add and the result keeps a's sign. With differing signs, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger; on equal magnitudes, a's sign is used before the zero rule applies.
- R4: Any magnitude above 0x7FFFFFFF sets `res_ovf` and saturates the magnitude to 0x7FFFFFFF, keeping the computed sign.
- R5: A result with zero magnitude always has sign bit 0.
- R6: Multiply: magnitude = floor(|a|·|b| / 2^16), and sign = sign(a) XOR sign(b).
- R7: Divide with a nonzero divisor: magnitude = floor(|a|·2^16 / |b|), and sign = sign(a) XOR sign(b).
- R8: Divide with a zero divisor magnitude sets `res_dz` (and not `res_ovf`), returns magnitude 0x7FFFFFFF with sign(a) XOR sign(b), and completes in a single step.
- R9: Square root: magnitude = floor(sqrt(|a|·2^16)), and the sign bit is 0.
- R10: Square root of an operand with sign 1 and a nonzero magnitude sets `res_err`, returns +0, and completes in a single step. An operand with sign 1 and zero magnitude gives +0 with no flag.
- R11: Counting the transfer edge as edge 0, `res_valid` is set by edge 0 for single-step commands, edge 32 for multiply, edge 48 for divide and edge 25 for square root.
- R12: Opcodes 5, 6 and 7 return +0 with all three flags clear, in a single step.
- R13: At most one of `res_ovf`, `res_dz` and `res_err` is set in any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Opcode (R1) |
| cmd_a | input | 32 | First operand, sign-magnitude |
| cmd_b | input | 32 | Second operand, sign-magnitude |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_val | output | 32 | Result word, sign-magnitude |
| res_ovf | output | 1 | Magnitude saturated |
| res_dz | output | 1 | Zero divisor |
| res_err | output | 1 | Square root of a negative operand |

## Verification
On every cycle, the assertions check that the two handshake channels stay mutually exclusive and that a waiting result is held. They also check that zero and square-root results are positive, that saturation pins the magnitude at its maximum, that the divide-by-zero flag comes only from a divide, that the flags are exclusive, and that single-step commands answer on the next cycle. The arithmetic values themselves can only be shown by the bench's scenarios, which compare each result against an independent wide-integer model. Those scenarios cover equal and opposite signs, both saturation directions, underflow to zero, zero and negative-zero operands, undefined opcodes, and the latency of each iterative operation measured under random consumer stalls.

// File: rtl/smfx_pkg.sv
package smfx_pkg;
  localparam int SMFX_MAG_W  = 31;
  localparam int SMFX_FRAC_W = 16;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_SQRT = 3'd4
  } smfx_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } smfx_st_e;
endpackage

// File: rtl/smfx_addsub.sv
module smfx_addsub #(
  parameter int MAG_W = 31
) (
  input  logic [MAG_W:0] a,
  input  logic [MAG_W:0] b,
  input  logic           sub,
  output logic [MAG_W:0] res,
  output logic           ovf
);
  logic             sa, eb, s;
  logic [MAG_W-1:0] am, bm, mag;
  logic [MAG_W:0]   sum;

  always_comb begin
    sa  = a[MAG_W];
    eb  = b[MAG_W] ^ sub;
    am  = a[MAG_W-1:0];
    bm  = b[MAG_W-1:0];
    sum = {1'b0, am} + {1'b0, bm};
    ovf = 1'b0;
    s   = sa;
    mag = '0;
    if (sa == eb) begin
      ovf = sum[MAG_W];
      mag = sum[MAG_W] ? {MAG_W{1'b1}} : sum[MAG_W-1:0];
    end else if (am >= bm) begin
      mag = am - bm;
    end else begin
      mag = bm - am;
      s   = eb;
    end
    res = {s && (mag != '0), mag};
  end
endmodule

// File: rtl/smfx_mul_iter.sv
module smfx_mul_iter #(
  parameter int MAG_W  = 31,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MAG_W-1:0] a,
  input  logic [MAG_W-1:0] b,
  output logic             done,
  output logic [MAG_W-1:0] mag,
  output logic             ovf
);
  localparam int PW = 2 * MAG_W;
  localparam int CW = $clog2(MAG_W + 1);

  logic [PW-1:0]    p;
  logic [MAG_W-1:0] mcand;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [MAG_W:0]   sum;

  always_comb sum = {1'b0, p[PW-1:MAG_W]} + (p[0] ? {1'b0, mcand} : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p <= '0; mcand <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        p     <= {{MAG_W{1'b0}}, b};
        mcand <= a;
        cnt   <= '0;
        run   <= 1'b1;
      end else if (run) begin
        p   <= {sum, p[MAG_W-1:1]};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(MAG_W - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign mag = p[FRAC_W +: MAG_W];
  assign ovf = |p[PW-1:FRAC_W+MAG_W];
endmodule

// File: rtl/smfx_div_iter.sv
module smfx_div_iter #(
  parameter int MAG_W  = 31,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MAG_W-1:0] a,
  input  logic [MAG_W-1:0] b,
  output logic             done,
  output logic [MAG_W-1:0] mag,
  output logic             ovf
);
  localparam int DW = MAG_W + FRAC_W;
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0]    q;
  logic [MAG_W-1:0] r, dsr, diff;
  logic [MAG_W:0]   sh;
  logic             ge;
  logic [CW-1:0]    cnt;
  logic             run;

  always_comb begin
    sh   = {r, q[DW-1]};
    ge   = sh >= {1'b0, dsr};
    diff = sh[MAG_W-1:0] - dsr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0; r <= '0; dsr <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q   <= {a, {FRAC_W{1'b0}}};
        r   <= '0;
        dsr <= b;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        r   <= ge ? diff : sh[MAG_W-1:0];
        q   <= {q[DW-2:0], ge};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(DW - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign mag = q[MAG_W-1:0];
  assign ovf = |q[DW-1:MAG_W];
endmodule

// File: rtl/smfx_sqrt_iter.sv
module smfx_sqrt_iter #(
  parameter int MAG_W  = 31,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MAG_W-1:0] a,
  output logic             done,
  output logic [MAG_W-1:0] mag
);
  localparam int RW   = (MAG_W + FRAC_W + 1) / 2;
  localparam int RADW = 2 * RW;
  localparam int CW   = $clog2(RW + 1);

  logic [RADW-1:0] rad;
  logic [RW-1:0]   root;
  logic [RW:0]     rem, diff;
  logic [RW+2:0]   shr;
  logic [RW+1:0]   trial;
  logic            ge;
  logic [CW-1:0]   cnt;
  logic            run;

  always_comb begin
    shr   = {rem, rad[RADW-1:RADW-2]};
    trial = {root, 2'b01};
    ge    = shr >= {1'b0, trial};
    diff  = shr[RW:0] - trial[RW:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad <= '0; root <= '0; rem <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rad  <= RADW'({a, {FRAC_W{1'b0}}});
        root <= '0;
        rem  <= '0;
        cnt  <= '0;
        run  <= 1'b1;
      end else if (run) begin
        rem  <= ge ? diff : shr[RW:0];
        root <= {root[RW-2:0], ge};
        rad  <= {rad[RADW-3:0], 2'b00};
        cnt  <= cnt + 1'b1;
        if (cnt == CW'(RW - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign mag = MAG_W'(root);
endmodule

// File: rtl/smfx_arith_unit.sv
module smfx_arith_unit
  import smfx_pkg::*;
#(
  parameter int MAG_W  = SMFX_MAG_W,
  parameter int FRAC_W = SMFX_FRAC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [2:0]     cmd_op,
  input  logic [MAG_W:0] cmd_a,
  input  logic [MAG_W:0] cmd_b,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [MAG_W:0] res_val,
  output logic           res_ovf,
  output logic           res_dz,
  output logic           res_err
);
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

  smfx_st_e         st;
  logic             accept, sa, sb, rsgn;
  logic [MAG_W-1:0] am, bm;
  logic             mul_sel, div_sel, sqrt_sel;
  logic [MAG_W:0]   as_res, q_res, it_res;
  logic             as_ovf, q_ovf, q_dz, q_err, it_ovf, it_done;
  logic             mul_done, div_done, sqrt_done, mul_ovf, div_ovf;
  logic [MAG_W-1:0] mul_mag, div_mag, sqrt_mag;

  assign cmd_ready = (st == ST_IDLE);
  assign res_valid = (st == ST_HOLD);
  assign accept    = cmd_valid && cmd_ready;
  assign sa = cmd_a[MAG_W];
  assign sb = cmd_b[MAG_W];
  assign am = cmd_a[MAG_W-1:0];
  assign bm = cmd_b[MAG_W-1:0];

  assign mul_sel  = (cmd_op == OP_MUL);
  assign div_sel  = (cmd_op == OP_DIV) && (bm != '0);
  assign sqrt_sel = (cmd_op == OP_SQRT) && !(sa && (am != '0));

  smfx_addsub #(.MAG_W(MAG_W)) u_addsub (
    .a(cmd_a), .b(cmd_b), .sub(cmd_op == OP_SUB), .res(as_res), .ovf(as_ovf)
  );

  smfx_mul_iter #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(accept && mul_sel), .a(am), .b(bm),
    .done(mul_done), .mag(mul_mag), .ovf(mul_ovf)
  );

  smfx_div_iter #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept && div_sel), .a(am), .b(bm),
    .done(div_done), .mag(div_mag), .ovf(div_ovf)
  );

  smfx_sqrt_iter #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_sqrt (
    .clk(clk), .rst_n(rst_n), .start(accept && sqrt_sel), .a(am),
    .done(sqrt_done), .mag(sqrt_mag)
  );

  function automatic logic [MAG_W:0] fold(input logic s, input logic [MAG_W-1:0] m,
                                          input logic o);
    if (o) return {s, MAG_MAX};
    if (m == '0) return '0;
    return {s, m};
  endfunction

  always_comb begin
    q_res = '0; q_ovf = 1'b0; q_dz = 1'b0; q_err = 1'b0;
    case (cmd_op)
      OP_ADD, OP_SUB: begin q_res = as_res; q_ovf = as_ovf; end
      OP_DIV:         begin q_res = {sa ^ sb, MAG_MAX}; q_dz = 1'b1; end
      OP_SQRT:        q_err = 1'b1;
      default:        ;
    endcase
  end

  always_comb begin
    it_done = mul_done || div_done || sqrt_done;
    it_ovf  = 1'b0;
    if (mul_done) begin
      it_res = fold(rsgn, mul_mag, mul_ovf); it_ovf = mul_ovf;
    end else if (div_done) begin
      it_res = fold(rsgn, div_mag, div_ovf); it_ovf = div_ovf;
    end else begin
      it_res = {1'b0, sqrt_mag};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; rsgn <= 1'b0;
      res_val <= '0; res_ovf <= 1'b0; res_dz <= 1'b0; res_err <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          rsgn <= sa ^ sb;
          if (!(mul_sel || div_sel || sqrt_sel)) begin
            res_val <= q_res; res_ovf <= q_ovf; res_dz <= q_dz; res_err <= q_err;
            st <= ST_HOLD;
          end else begin
            st <= ST_BUSY;
          end
        end
        ST_BUSY: if (it_done) begin
          res_val <= it_res; res_ovf <= it_ovf; res_dz <= 1'b0; res_err <= 1'b0;
          st <= ST_HOLD;
        end
        ST_HOLD: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smfx_arith_chk.sv
module smfx_arith_chk #(
  parameter int MAG_W = 31
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [2:0]     cmd_op,
  input logic           res_valid,
  input logic           res_ready,
  input logic [MAG_W:0] res_val,
  input logic           res_ovf,
  input logic           res_dz,
  input logic           res_err
);
  logic [2:0] last_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_op <= 3'd0;
    else if (cmd_valid && cmd_ready) last_op <= cmd_op;
  end

  assert_chan_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && res_valid));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_val) && $stable(res_ovf)
                                && $stable(res_dz) && $stable(res_err));

  assert_addsub_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_op == 3'd0 || cmd_op == 3'd1) |=> res_valid);

  assert_zero_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_val[MAG_W-1:0] == '0) |-> !res_val[MAG_W]);

  assert_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ovf |-> (res_val[MAG_W-1:0] == {MAG_W{1'b1}}));

  assert_sqrt_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (last_op == 3'd4) |-> !res_val[MAG_W]);

  assert_dz_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_dz |-> (last_op == 3'd3));

  assert_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0({res_ovf, res_dz, res_err}));
endmodule

bind smfx_arith_unit smfx_arith_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .res_valid(res_valid), .res_ready(res_ready),
  .res_val(res_val), .res_ovf(res_ovf), .res_dz(res_dz), .res_err(res_err)
);

// File: tb/sim_smfx_arith_unit.sv
module sim_smfx_arith_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_val;
  logic        res_ovf, res_dz, res_err;

  int total = 0, bad = 0, cyc = 0;
  bit live = 0, stall_on = 0, ended = 0;

  typedef struct {
    logic [31:0] val;
    logic [2:0]  fl;
    int          lat;
    int          acc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  smfx_arith_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .res_valid(res_valid),
    .res_ready(res_ready), .res_val(res_val), .res_ovf(res_ovf),
    .res_dz(res_dz), .res_err(res_err)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  localparam longint unsigned MAXM = 64'h7FFF_FFFF;

  function automatic longint unsigned isqrt(input longint unsigned x);
    longint unsigned lo = 0, hi = 64'd1 << 24, mid;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= x) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  // Expected result from R1, R3..R12; flags ordered {ovf, dz, err}
  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] val, output logic [2:0] fl, output int lat);
    longint unsigned am = a[30:0], bm = b[30:0], r = 0;
    bit s = 0, eb;
    fl = 3'b000; lat = 0;
    case (op)
      3'd0, 3'd1: begin
        eb = b[31] ^ (op == 3'd1);
        if (a[31] == eb) begin r = am + bm; s = a[31]; end
        else if (am >= bm) begin r = am - bm; s = a[31]; end
        else begin r = bm - am; s = eb; end
      end
      3'd2: begin r = (am * bm) >> 16; s = a[31] ^ b[31]; lat = 32; end
      3'd3: begin
        s = a[31] ^ b[31];
        if (bm == 0) begin r = MAXM; fl[1] = 1'b1; end
        else begin r = (am << 16) / bm; lat = 48; end
      end
      3'd4: begin
        if (a[31] && am != 0) fl[0] = 1'b1;
        else begin r = isqrt(am << 16); lat = 25; end
      end
      default: ;
    endcase
    if (r > MAXM) begin r = MAXM; fl[2] = 1'b1; end
    if (r == 0) s = 0;
    val = {s, r[30:0]};
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      input string tag);
    exp_t e;
    model(op, a, b, e.val, e.fl, e.lat);
    e.tag = tag;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    e.acc = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // consumer stalls
  initial forever begin
    @(negedge clk);
    res_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  bit seen = 0, hold_prev = 0;
  logic [34:0] prev;
  always @(negedge clk) begin
    #1;
    if (live && res_valid) begin
      if (hold_prev) begin
        total++;
        if ({res_val, res_ovf, res_dz, res_err} !== prev) begin
          bad++;
          $display("FAIL R2 hold actual=%h expected=%h", {res_val, res_ovf, res_dz, res_err}, prev);
        end
      end
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected result actual=%h expected=none", res_val);
      end else begin
        if (!seen) begin
          seen = 1; total++;
          if (cyc - sb[0].acc != sb[0].lat) begin
            bad++;
            $display("FAIL R11 latency (%s) actual=%0d expected=%0d", sb[0].tag,
                     cyc - sb[0].acc, sb[0].lat);
          end
        end
        if (res_ready) begin
          total++;
          if (res_val !== sb[0].val || {res_ovf, res_dz, res_err} !== sb[0].fl) begin
            bad++;
            $display("FAIL %s actual=%h/%b expected=%h/%b", sb[0].tag, res_val,
                     {res_ovf, res_dz, res_err}, sb[0].val, sb[0].fl);
          end
          void'(sb.pop_front());
          seen = 0;
        end
      end
      hold_prev = !res_ready;
      prev = {res_val, res_ovf, res_dz, res_err};
    end else begin
      hold_prev = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=all results");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    total++;
    if (cmd_ready !== 1'b1 || res_valid !== 1'b0) begin
      bad++;
      $display("FAIL R2 reset actual=%b%b expected=10", cmd_ready, res_valid);
    end
    live = 1;

    send(3'd0, 32'h0001_8000, 32'h0002_4000, "R1/R3 add same sign");
    send(3'd0, 32'h0001_0000, 32'h8003_0000, "R3 add opposite");
    send(3'd1, 32'h8002_0000, 32'h8005_0000, "R3 sub negatives");
    send(3'd1, 32'h0005_0000, 32'h0005_0000, "R5 sub equal");
    send(3'd0, 32'h8002_0000, 32'h0002_0000, "R5 add cancel");
    send(3'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R4 add saturate +");
    send(3'd1, 32'hFFFF_FFFF, 32'h0000_0001, "R4 sub saturate -");
    send(3'd2, 32'h8001_8000, 32'h0002_0000, "R6 mul sign");
    send(3'd2, 32'h7FFF_0000, 32'h0002_0000, "R4/R6 mul overflow");
    send(3'd2, 32'h0000_0001, 32'h8000_0001, "R5/R6 mul underflow");
    send(3'd3, 32'h0003_0000, 32'h8002_0000, "R7 div");
    send(3'd3, 32'h7FFF_FFFF, 32'h0000_0001, "R4/R7 div overflow");
    send(3'd3, 32'h8000_0005, 32'h0000_0000, "R8 div zero");
    send(3'd3, 32'h0000_0000, 32'h8000_0000, "R8 div zero by -0");
    send(3'd4, 32'h0004_0000, 32'h0, "R9 sqrt 4");
    send(3'd4, 32'h0002_0000, 32'h0, "R9 sqrt 2");
    send(3'd4, 32'h7FFF_FFFF, 32'h0, "R9 sqrt max");
    send(3'd4, 32'h8004_0000, 32'h0, "R10 sqrt negative");
    send(3'd4, 32'h8000_0000, 32'h0, "R10 sqrt -0");
    send(3'd5, 32'h0001_0000, 32'h0001_0000, "R12 op5");
    send(3'd7, 32'h8123_4567, 32'h0765_4321, "R12 op7");

    stall_on = 1;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      ra = {1'($urandom), 31'($urandom) >> ($urandom % 24)};
      rb = {1'($urandom), 31'($urandom) >> ($urandom % 24)};
      send(3'($urandom % 6), ra, rb, "R13 random mix");
    end
    stall_on = 0;

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule